// File: doc/BRIEF.md
# Programming-Control Register Unlock Guard

This block holds the control register that steers in-system reprogramming of on-chip program storage. It sits on a simple special-function-register bus, which carries an address, write data, a write strobe and combinational read data. The control register holds four live bits: a software-reset request, an auxiliary-RAM enable, a loader-location select and a programming enable. After reset, software cannot change the register. It becomes writable only after two key bytes, 87h and then 59h, are written to a separate key register. Any other byte written to the key register closes it again.

Once a write leaves the reset-request, loader-select and programming-enable bits all set, the block issues a one-cycle software-reset pulse. That pulse returns the register, the key sequencer and the mode tracker to their reset state. Setting the programming-enable bit does not switch modes immediately. The switch to loader execution happens only when the processor sits idle and an interrupt wakes it. At that moment the block raises a loader-active flag and gives a one-cycle request to clear the program counter.

Top module: `isp_unlock_ctrl`

## Requirements
- R1: While the control register is locked, writes to its address leave every stored bit and output unchanged.
- R2: Two writes to the key register, 87h and then 59h with no other key-register write between them, unlock the control register for every following write. Writes to other addresses between the two key bytes do not break the sequence.
- R3: While unlocked, a key-register write of 87h or 59h keeps the register unlocked. A key-register write of any other value locks it, effective from the next write.
- R4: After 87h, any key-register byte other than 59h, including a second 87h, returns the sequencer to waiting for 87h. So 87h,42h,59h and 87h,87h,59h both leave the register locked.
- R5: Control bit positions: bit 7 is the reset request (`swrst_req_o`), bit 4 is the auxiliary-RAM enable (`auxram_en_o`), bit 1 is the loader select (`boot_sel_o`) and bit 0 is the programming enable (`prog_en_o`). Bits 6, 5, 3 and 2 are not stored and read as 0.
- R6: A read at the control address returns the stored bits, except that bit 7 carries `boot_status_i`. Reads at the key address or at any other address return 00h.
- R7: Reset clears all control bits, so the auxiliary RAM is disabled, and leaves the register locked.
- R8: When stored bits 7, 1 and 0 are all 1, `swrst_pulse_o` is high for exactly one cycle: the cycle after the write. The next edge clears the control register, relocks it and clears loader mode.
- R9: When the programming enable is set and `wake_irq_i` arrives while `cpu_idle_i` is high, `loader_active_o` rises and `pc_clear_o` pulses for one cycle. A wake without idle, or a wake without the programming enable, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | ADDR_W | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Write strobe |
| sfr_rdata | output | 8 | Read data for the addressed register |
| boot_status_i | input | 1 | Loader-boot status, returned in bit 7 on reads |
| cpu_idle_i | input | 1 | Processor is in idle |
| wake_irq_i | input | 1 | Interrupt that wakes the processor |
| swrst_req_o | output | 1 | Stored reset-request bit |
| auxram_en_o | output | 1 | Auxiliary RAM enable |
| boot_sel_o | output | 1 | Loader location select |
| prog_en_o | output | 1 | Programming enable |
| swrst_pulse_o | output | 1 | One-cycle software reset |
| loader_active_o | output | 1 | Executing from the loader after the wake switch |
| pc_clear_o | output | 1 | One-cycle program-counter clear request |

## Verification
The hardest state to reach is a key sequence that fails only because of its ordering. A stray byte or a repeated 87h must not unlock the register, while a write to another address between the two key bytes must not break the sequence. A table of bus writes walks through these orderings, and the bench reads the control register back after each write. The software-reset cycle is reached by writing the trigger pattern while unlocked. Loader mode is reached by setting the programming enable and then raising wake with idle held low, then with idle held high.

// File: rtl/isp_unlock_pkg.sv
package isp_unlock_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_SWRST = 7;
  localparam int BIT_AUX   = 4;
  localparam int BIT_BSEL  = 1;
  localparam int BIT_PEN   = 0;

  localparam logic [BYTE_W-1:0] STORE_MASK =
    BYTE_W'((1 << BIT_SWRST) | (1 << BIT_AUX) | (1 << BIT_BSEL) | (1 << BIT_PEN));

  typedef enum logic [1:0] {
    KEY_WAIT = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_t;

  // next sequencer state for one key-register write
  function automatic key_state_t key_step(
    input key_state_t        cur,
    input logic [BYTE_W-1:0] d,
    input logic [BYTE_W-1:0] k1,
    input logic [BYTE_W-1:0] k2
  );
    key_state_t nxt;
    case (cur)
      KEY_WAIT: nxt = (d == k1) ? KEY_HALF : KEY_WAIT;
      KEY_HALF: nxt = (d == k2) ? KEY_OPEN : KEY_WAIT;
      KEY_OPEN: nxt = ((d == k1) || (d == k2)) ? KEY_OPEN : KEY_WAIT;
      default:  nxt = KEY_WAIT;
    endcase
    return nxt;
  endfunction

  // software reset trigger: request, loader select and programming enable
  function automatic logic swrst_armed(input logic [BYTE_W-1:0] c);
    return c[BIT_SWRST] & c[BIT_BSEL] & c[BIT_PEN];
  endfunction

  // value presented on a read of the control register
  function automatic logic [BYTE_W-1:0] ctrl_view(
    input logic [BYTE_W-1:0] c,
    input logic              status
  );
    logic [BYTE_W-1:0] v;
    v = c & STORE_MASK;
    v[BIT_SWRST] = status;
    return v;
  endfunction
endpackage

// File: rtl/isp_key_seq.sv
module isp_key_seq
  import isp_unlock_pkg::*;
#(
  parameter logic [BYTE_W-1:0] KEY_FIRST  = 8'h87,
  parameter logic [BYTE_W-1:0] KEY_SECOND = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [BYTE_W-1:0] key_data,
  input  logic              clear,
  output key_state_t        state,
  output logic              first_seen,
  output logic              unlocked
);
  key_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= KEY_WAIT;
    else if (clear)   state_q <= KEY_WAIT;
    else if (key_we)  state_q <= key_step(state_q, key_data, KEY_FIRST, KEY_SECOND);
  end

  assign state      = state_q;
  assign first_seen = (state_q == KEY_HALF);
  assign unlocked   = (state_q == KEY_OPEN);
endmodule

// File: rtl/isp_ctrl_reg.sv
module isp_ctrl_reg
  import isp_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              clear,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              swrst_fire
);
  logic [BYTE_W-1:0] ctrl_r;

  // only the live bit positions get a flop; the rest tie to zero
  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    if (STORE_MASK[b]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_r[b] <= 1'b0;
        else if (clear)  ctrl_r[b] <= 1'b0;
        else if (wr_en)  ctrl_r[b] <= wdata[b];
      end
    end else begin : g_tie
      assign ctrl_r[b] = 1'b0;
    end
  end

  assign ctrl_q     = ctrl_r;
  assign swrst_fire = swrst_armed(ctrl_r);
endmodule

// File: rtl/isp_mode_tracker.sv
module isp_mode_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_en,
  input  logic cpu_idle,
  input  logic wake_irq,
  input  logic clear,
  output logic loader_active,
  output logic pc_clear
);
  logic loader_q;
  logic pc_clear_q;
  logic enter;

  assign enter = prog_en & cpu_idle & wake_irq & ~loader_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loader_q   <= 1'b0;
      pc_clear_q <= 1'b0;
    end else if (clear) begin
      loader_q   <= 1'b0;
      pc_clear_q <= 1'b0;
    end else begin
      loader_q   <= loader_q | enter;
      pc_clear_q <= enter;
    end
  end

  assign loader_active = loader_q;
  assign pc_clear      = pc_clear_q;
endmodule

// File: rtl/isp_unlock_ctrl.sv
module isp_unlock_ctrl
  import isp_unlock_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hF6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hBF,
  parameter logic [7:0]        KEY_FIRST  = 8'h87,
  parameter logic [7:0]        KEY_SECOND = 8'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              sfr_we,
  output logic [7:0]        sfr_rdata,
  input  logic              boot_status_i,
  input  logic              cpu_idle_i,
  input  logic              wake_irq_i,
  output logic              swrst_req_o,
  output logic              auxram_en_o,
  output logic              boot_sel_o,
  output logic              prog_en_o,
  output logic              swrst_pulse_o,
  output logic              loader_active_o,
  output logic              pc_clear_o
);
  // named internal events, visible to the bound checker
  logic              key_wr_w;
  logic              ctrl_wr_w;
  logic              ctrl_wr_ok_w;
  logic              unlocked_w;
  logic              first_seen_w;
  logic              swrst_w;
  key_state_t        key_state_w;
  logic [BYTE_W-1:0] ctrl_w;

  assign key_wr_w     = sfr_we & (sfr_addr == KEY_ADDR);
  assign ctrl_wr_w    = sfr_we & (sfr_addr == CTRL_ADDR);
  assign ctrl_wr_ok_w = ctrl_wr_w & unlocked_w;

  isp_key_seq #(
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_we     (key_wr_w),
    .key_data   (sfr_wdata),
    .clear      (swrst_w),
    .state      (key_state_w),
    .first_seen (first_seen_w),
    .unlocked   (unlocked_w)
  );

  isp_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctrl_wr_ok_w),
    .wdata      (sfr_wdata),
    .clear      (swrst_w),
    .ctrl_q     (ctrl_w),
    .swrst_fire (swrst_w)
  );

  isp_mode_tracker u_mode (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_en       (ctrl_w[BIT_PEN]),
    .cpu_idle      (cpu_idle_i),
    .wake_irq      (wake_irq_i),
    .clear         (swrst_w),
    .loader_active (loader_active_o),
    .pc_clear      (pc_clear_o)
  );

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == CTRL_ADDR) sfr_rdata = ctrl_view(ctrl_w, boot_status_i);
  end

  assign swrst_req_o   = ctrl_w[BIT_SWRST];
  assign auxram_en_o   = ctrl_w[BIT_AUX];
  assign boot_sel_o    = ctrl_w[BIT_BSEL];
  assign prog_en_o     = ctrl_w[BIT_PEN];
  assign swrst_pulse_o = swrst_w;
endmodule

// File: rtl/isp_unlock_chk.sv
module isp_unlock_chk #(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hF6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hBF,
  parameter logic [7:0]        KEY_FIRST  = 8'h87,
  parameter logic [7:0]        KEY_SECOND = 8'h59
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [7:0]        sfr_wdata,
  input logic [7:0]        sfr_rdata,
  input logic              boot_status_i,
  input logic              key_wr,
  input logic              ctrl_wr,
  input logic              unlocked,
  input logic              first_seen,
  input logic [7:0]        ctrl,
  input logic              swrst_pulse,
  input logic              loader_active,
  input logic              pc_clear
);
  // R1
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !unlocked && !swrst_pulse) |=> $stable(ctrl));

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_seen && key_wr && sfr_wdata == KEY_SECOND && !swrst_pulse) |=> unlocked);

  // R3
  key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_wr && sfr_wdata != KEY_FIRST && sfr_wdata != KEY_SECOND) |=> !unlocked);

  // R4
  key_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_seen && key_wr && sfr_wdata != KEY_SECOND) |=> (!unlocked && !first_seen));

  // R6
  read_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr != CTRL_ADDR) |-> (sfr_rdata == 8'h00));

  // R6
  read_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == CTRL_ADDR) |-> (sfr_rdata[7] == boot_status_i));

  // R8
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |=> (!swrst_pulse && ctrl == 8'h00 && !unlocked && !loader_active));

  // R9
  pc_clear_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_clear |=> !pc_clear);

  // R9
  pc_clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_clear |-> loader_active);
endmodule

bind isp_unlock_ctrl isp_unlock_chk #(
  .ADDR_W     (ADDR_W),
  .KEY_ADDR   (KEY_ADDR),
  .CTRL_ADDR  (CTRL_ADDR),
  .KEY_FIRST  (KEY_FIRST),
  .KEY_SECOND (KEY_SECOND)
) u_isp_unlock_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sfr_addr      (sfr_addr),
  .sfr_wdata     (sfr_wdata),
  .sfr_rdata     (sfr_rdata),
  .boot_status_i (boot_status_i),
  .key_wr        (key_wr_w),
  .ctrl_wr       (ctrl_wr_w),
  .unlocked      (unlocked_w),
  .first_seen    (first_seen_w),
  .ctrl          (ctrl_w),
  .swrst_pulse   (swrst_w),
  .loader_active (loader_active_o),
  .pc_clear      (pc_clear_o)
);

// File: tb/test_isp_unlock_ctrl.sv
module test_isp_unlock_ctrl;
  localparam logic [7:0] KEY_A  = 8'hF6;
  localparam logic [7:0] CTRL_A = 8'hBF;
  localparam int NVEC = 23;
  // {is_key_write, data, expected control readback}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'h13, 8'h00}, {1'b1, 8'h87, 8'h00}, {1'b0, 8'h10, 8'h00},
    {1'b1, 8'h59, 8'h00}, {1'b0, 8'h7C, 8'h10}, {1'b0, 8'h03, 8'h03},
    {1'b1, 8'h59, 8'h03}, {1'b0, 8'h12, 8'h12}, {1'b1, 8'h87, 8'h12},
    {1'b0, 8'h11, 8'h11}, {1'b1, 8'h00, 8'h11}, {1'b0, 8'h01, 8'h11},
    {1'b1, 8'h87, 8'h11}, {1'b1, 8'h42, 8'h11}, {1'b1, 8'h59, 8'h11},
    {1'b0, 8'h01, 8'h11}, {1'b1, 8'h87, 8'h11}, {1'b1, 8'h87, 8'h11},
    {1'b1, 8'h59, 8'h11}, {1'b0, 8'h02, 8'h11}, {1'b1, 8'h87, 8'h11},
    {1'b1, 8'h59, 8'h11}, {1'b0, 8'h80, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic       boot_status_i = 1'b0;
  logic       cpu_idle_i = 1'b0;
  logic       wake_irq_i = 1'b0;
  logic       swrst_req_o, auxram_en_o, boot_sel_o, prog_en_o;
  logic       swrst_pulse_o, loader_active_o, pc_clear_o;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  isp_unlock_ctrl i_isp_unlock_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .boot_status_i(boot_status_i),
    .cpu_idle_i(cpu_idle_i), .wake_irq_i(wake_irq_i),
    .swrst_req_o(swrst_req_o), .auxram_en_o(auxram_en_o),
    .boot_sel_o(boot_sel_o), .prog_en_o(prog_en_o),
    .swrst_pulse_o(swrst_pulse_o), .loader_active_o(loader_active_o),
    .pc_clear_o(pc_clear_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd_ctrl(output logic [7:0] v);
    sfr_addr = CTRL_A;
    #1 v = sfr_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic string vec_tag(input int i);
    if (i < 3)  return "R1";
    if (i == 3) return "R2";
    if (i < 6)  return "R5";
    if (i < 12) return "R3";
    if (i < 20) return "R4";
    return "R6";
  endfunction

  function automatic logic [7:0] outs();
    return {swrst_req_o, 2'b00, auxram_en_o, swrst_pulse_o, loader_active_o, boot_sel_o, prog_en_o};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    rd_ctrl(v);
    check("R7 reset readback", v, 8'h00);
    check("R7 reset outputs", outs(), 8'h00);
    // R9 wake without programming enable
    @(negedge clk);
    cpu_idle_i = 1'b1; wake_irq_i = 1'b1;
    @(negedge clk);
    wake_irq_i = 1'b0; cpu_idle_i = 1'b0;
    check("R9 wake without enable", {6'b0, loader_active_o, pc_clear_o}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][16] ? KEY_A : CTRL_A, VEC[i][15:8]);
      rd_ctrl(v);
      check(vec_tag(i), v, VEC[i][7:0]);
    end
    // R5 stored request bit reaches its output though reads show status
    check("R5 request output", {7'b0, swrst_req_o}, 8'h01);
    // R6 status in bit 7, other addresses read zero
    wr(CTRL_A, 8'h12);
    boot_status_i = 1'b1;
    rd_ctrl(v);
    check("R6 status bit", v, 8'h92);
    boot_status_i = 1'b0;
    sfr_addr = KEY_A;
    #1 check("R6 key address read", sfr_rdata, 8'h00);
    sfr_addr = 8'h33;
    #1 check("R6 unmapped read", sfr_rdata, 8'h00);
    check("R5 output bits", outs(), 8'h12);

    // R7 reset relocks
    do_reset();
    wr(CTRL_A, 8'h10);
    rd_ctrl(v);
    check("R7 locked after reset", v, 8'h00);

    // R9 loader entry
    wr(KEY_A, 8'h87);
    wr(KEY_A, 8'h59);
    wr(CTRL_A, 8'h01);
    @(negedge clk);
    wake_irq_i = 1'b1;
    @(negedge clk);
    wake_irq_i = 1'b0;
    check("R9 wake without idle", {6'b0, loader_active_o, pc_clear_o}, 8'h00);
    cpu_idle_i = 1'b1; wake_irq_i = 1'b1;
    @(negedge clk);
    wake_irq_i = 1'b0; cpu_idle_i = 1'b0;
    check("R9 loader entry", {6'b0, loader_active_o, pc_clear_o}, 8'h03);
    @(negedge clk);
    check("R9 pc clear single", {6'b0, loader_active_o, pc_clear_o}, 8'h02);

    // R8 software reset
    wr(CTRL_A, 8'h93);
    check("R8 pulse cycle", outs(), 8'h9F);
    @(negedge clk);
    check("R8 after pulse", outs(), 8'h00);
    wr(CTRL_A, 8'h10);
    rd_ctrl(v);
    check("R8 relocked", v, 8'h00);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule